// File: doc/BRIEF.md
# Speculative Store Queue with Load Forwarding

This block is a circular queue of store requests, each an address and a data word, kept in program order. Every live entry is either speculative or retired. Speculative entries run from the retire pointer up to the tail. Retired entries run from the head up to the retire pointer and are waiting to be written to memory. New stores enter at the tail. A retire strobe moves one entry from the speculative region into the retired region. The oldest retired entry is offered on a memory write port and leaves the queue once that port accepts it. Because of this, a store reaches memory some time after it retires.

A combinational lookup port lets a load check the queue for its address. If any live entry matches, the port returns the data of the youngest matching entry and raises a hit flag. If nothing matches, the hit flag stays low and the load reads memory. A partial flush takes a slot index and discards every entry younger than that slot. Retired entries always survive a flush.

Top module: `store_queue_fwd`

## Requirements
- R1: After reset the queue is empty: `pushReady` is 1, `memWrValid` is 0 and `lookupHit` is 0 for any address.
- R2: A store is accepted in a cycle with `pushValid` and `pushReady` both high. `pushReady` is 0 while DEPTH entries are live, and a push that is refused changes nothing.
- R3: When one or more live entries hold `lookupAddr`, `lookupHit` is 1 in the same cycle and `lookupData` is the data of the most recently pushed of them.
- R4: When no live entry holds `lookupAddr`, `lookupHit` is 0. Entries that were committed or flushed do not match.
- R5: `retireReq` moves the oldest speculative entry into the retired region. When no speculative entry exists, `retireReq` is ignored.
- R6: `memWrValid` is 1 exactly while at least one retired entry exists. `memWrAddr` and `memWrData` then show the oldest entry, and it is removed at a clock edge where `memWrReady` is 1.
- R7: A retired entry stays in the queue, and remains visible to lookups, for as long as `memWrReady` is held at 0.
- R8: A flush with `flushIdx` naming a live slot keeps that slot and every older entry. It discards all younger entries, so the next push lands in slot `flushIdx + 1` (mod DEPTH).
- R9: A flush never discards retired entries. When `flushIdx` names a retired slot other than the youngest retired one, only the speculative entries are removed. When `flushIdx` names no live slot, the flush is ignored.
- R10: Push, retire and commit can all take effect in the same cycle. In a cycle with `flushReq` high, `pushReady` is 0 and the push is dropped, while retire and commit still apply to the entries that remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | New store offered |
| pushAddr | input | ADDR_W | Address of the new store |
| pushData | input | DATA_W | Data of the new store |
| pushReady | output | 1 | Queue can accept a store this cycle |
| retireReq | input | 1 | Retire the oldest speculative store |
| flushReq | input | 1 | Discard entries younger than `flushIdx` |
| flushIdx | input | log2(DEPTH) | Slot of the youngest entry to keep |
| lookupAddr | input | ADDR_W | Load address to search for |
| lookupHit | output | 1 | A live entry matches `lookupAddr` |
| lookupData | output | DATA_W | Data of the youngest matching entry |
| memWrValid | output | 1 | Oldest retired store is offered to memory |
| memWrAddr | output | ADDR_W | Address of the offered store |
| memWrData | output | DATA_W | Data of the offered store |
| memWrReady | input | 1 | Memory accepts the offered store |

## Verification
The lookup is tried against a queue holding several stores to one address, which separates the youngest match from the oldest or any other match. It is also tried against addresses that were never pushed and addresses that were already drained or flushed, which separates live entries from stale slot contents. Flushes are aimed at a speculative slot, at a retired slot and at an empty slot, so a plain cut can be told apart from the clamp that protects retired stores and from an ignored request. A long run of random pushes, retires, commits and flushes over a small address set then checks the interactions within a single cycle against a queue model cycle by cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // strobes issued by the pointer control to the storage datapath
  typedef struct packed {
    logic write;   // store the incoming entry at the tail slot
    logic pop;     // oldest retired entry leaves toward memory
    logic retire;  // retire pointer advances
    logic cut;     // partial flush applied
  } sqStrobes_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pushValid,
  input  logic                       retireReq,
  input  logic                       flushReq,
  input  logic [$clog2(DEPTH)-1:0]   flushIdx,
  input  logic                       memWrReady,
  output logic                       pushReady,
  output logic                       memWrValid,
  output sqStrobes_t                 strobes,
  output logic [$clog2(DEPTH)-1:0]   headSlot,
  output logic [$clog2(DEPTH)-1:0]   tailSlot,
  output logic [$clog2(DEPTH):0]     liveCount
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, retPtr, tailPtr;
  logic [PTR_W-1:0] retCount, relExt, keepLen, cutTail;
  logic [IDX_W-1:0] rel;
  logic             flushHit;

  assign liveCount = tailPtr - headPtr;
  assign retCount  = retPtr - headPtr;
  assign headSlot  = headPtr[IDX_W-1:0];
  assign tailSlot  = tailPtr[IDX_W-1:0];

  assign pushReady  = (liveCount != PTR_W'(DEPTH)) && !flushReq;
  assign memWrValid = (retPtr != headPtr);

  always_comb begin
    rel      = flushIdx - headSlot;
    relExt   = {1'b0, rel};
    keepLen  = relExt + PTR_W'(1);
    flushHit = flushReq && (relExt < liveCount);
    cutTail  = tailPtr;
    if (flushHit) begin
      cutTail = (keepLen < retCount) ? retPtr : headPtr + keepLen;
    end
  end

  always_comb begin
    strobes.cut    = flushHit;
    strobes.retire = retireReq && (retPtr != cutTail);
    strobes.pop    = memWrValid && memWrReady;
    strobes.write  = pushValid && pushReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      retPtr  <= '0;
      tailPtr <= '0;
    end else begin
      if (strobes.pop)    headPtr <= headPtr + PTR_W'(1);
      if (strobes.retire) retPtr  <= retPtr + PTR_W'(1);
      tailPtr <= cutTail + (strobes.write ? PTR_W'(1) : PTR_W'(0));
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    liveCount <= PTR_W'(DEPTH));
  p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (liveCount == PTR_W'(DEPTH)) |-> !strobes.write);
  p_retired_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retCount <= liveCount);
  p_flush_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.cut && !strobes.pop) |=> (liveCount >= $past(retCount)));
  p_commit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.pop |=> (headSlot == $past(headSlot) + IDX_W'(1)));
endmodule

// File: rtl/sq_data.sv
module sq_data
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  sqStrobes_t                strobes,
  input  logic [$clog2(DEPTH)-1:0]  headSlot,
  input  logic [$clog2(DEPTH)-1:0]  tailSlot,
  input  logic [$clog2(DEPTH):0]    liveCount,
  input  logic [ADDR_W-1:0]         pushAddr,
  input  logic [DATA_W-1:0]         pushData,
  input  logic [ADDR_W-1:0]         lookupAddr,
  output logic                      lookupHit,
  output logic [DATA_W-1:0]         lookupData,
  output logic [ADDR_W-1:0]         memWrAddr,
  output logic [DATA_W-1:0]         memWrData
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  ageMatch;   // bit k: entry k places after head matches
  logic [DATA_W-1:0] ageData [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.write) begin
      addrMem[tailSlot] <= pushAddr;
      dataMem[tailSlot] <= pushData;
    end
  end

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [IDX_W-1:0] slot;
      assign slot        = headSlot + IDX_W'(k);
      assign ageMatch[k] = (PTR_W'(k) < liveCount) && (addrMem[slot] == lookupAddr);
      assign ageData[k]  = dataMem[slot];
    end
  endgenerate

  // younger entries sit at larger ages; the last match found wins
  always_comb begin
    lookupHit  = 1'b0;
    lookupData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (ageMatch[k]) begin
        lookupHit  = 1'b1;
        lookupData = ageData[k];
      end
    end
  end

  assign memWrAddr = addrMem[headSlot];
  assign memWrData = dataMem[headSlot];

  p_hit_needs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lookupHit |-> (liveCount != '0));
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.write |=> (dataMem[$past(tailSlot)] == $past(pushData)));
endmodule

// File: rtl/store_queue_fwd.sv
module store_queue_fwd
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pushValid,
  input  logic [ADDR_W-1:0]         pushAddr,
  input  logic [DATA_W-1:0]         pushData,
  output logic                      pushReady,
  input  logic                      retireReq,
  input  logic                      flushReq,
  input  logic [$clog2(DEPTH)-1:0]  flushIdx,
  input  logic [ADDR_W-1:0]         lookupAddr,
  output logic                      lookupHit,
  output logic [DATA_W-1:0]         lookupData,
  output logic                      memWrValid,
  output logic [ADDR_W-1:0]         memWrAddr,
  output logic [DATA_W-1:0]         memWrData,
  input  logic                      memWrReady
);
  localparam int IDX_W = $clog2(DEPTH);

  sqStrobes_t        strobes;
  logic [IDX_W-1:0]  headSlot, tailSlot;
  logic [IDX_W:0]    liveCount;

  sq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pushValid(pushValid), .retireReq(retireReq),
    .flushReq(flushReq), .flushIdx(flushIdx),
    .memWrReady(memWrReady),
    .pushReady(pushReady), .memWrValid(memWrValid),
    .strobes(strobes), .headSlot(headSlot), .tailSlot(tailSlot),
    .liveCount(liveCount)
  );

  sq_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .headSlot(headSlot), .tailSlot(tailSlot), .liveCount(liveCount),
    .pushAddr(pushAddr), .pushData(pushData),
    .lookupAddr(lookupAddr), .lookupHit(lookupHit), .lookupData(lookupData),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
endmodule

// File: tb/tb_store_queue_fwd.sv
module tb_store_queue_fwd;
  localparam int DEPTH  = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic pushValid, retireReq, flushReq, memWrReady;
  logic [ADDR_W-1:0] pushAddr, lookupAddr;
  logic [DATA_W-1:0] pushData;
  logic [IDX_W-1:0]  flushIdx;
  logic pushReady, lookupHit, memWrValid;
  logic [DATA_W-1:0] lookupData, memWrData;
  logic [ADDR_W-1:0] memWrAddr;

  always #2 clk = ~clk;   // 250 MHz

  store_queue_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .pushValid(pushValid), .pushAddr(pushAddr), .pushData(pushData),
    .pushReady(pushReady), .retireReq(retireReq),
    .flushReq(flushReq), .flushIdx(flushIdx),
    .lookupAddr(lookupAddr), .lookupHit(lookupHit), .lookupData(lookupData),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrReady(memWrReady)
  );

  // reference model: program-ordered queue plus retired count
  int qa[$];
  int qd[$];
  int retCnt   = 0;
  int headSlot = 0;
  int nChecks  = 0;
  int nFail    = 0;
  bit done     = 0;
  string curReq = "R1";

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  function automatic int slotOf(input int age);
    return (headSlot + age) % DEPTH;
  endfunction

  task automatic step(input bit pv, input int pa, input int pd, input bit rr,
                      input bit fr, input int fi, input bit mr, input int la);
    int cnt, rel, newLen, oldRet, hitIdx;
    bit expReady, expWv, doPop;
    @(negedge clk);
    pushValid = pv; pushAddr = ADDR_W'(pa); pushData = DATA_W'(pd);
    retireReq = rr; flushReq = fr; flushIdx = IDX_W'(fi);
    memWrReady = mr; lookupAddr = ADDR_W'(la);
    #1;
    cnt      = qa.size();
    expReady = (cnt < DEPTH) && !fr;
    expWv    = (retCnt > 0);
    hitIdx   = -1;
    for (int i = 0; i < cnt; i++) if (qa[i] == la) hitIdx = i;
    chk(pushReady == expReady, "pushReady", int'(pushReady), int'(expReady));
    chk(memWrValid == expWv, "memWrValid", int'(memWrValid), int'(expWv));
    if (expWv) begin
      chk(int'(memWrAddr) == qa[0], "memWrAddr", int'(memWrAddr), qa[0]);
      chk(int'(memWrData) == qd[0], "memWrData", int'(memWrData), qd[0]);
    end
    chk(lookupHit == (hitIdx >= 0), "lookupHit", int'(lookupHit), int'(hitIdx >= 0));
    if (hitIdx >= 0)
      chk(int'(lookupData) == qd[hitIdx], "lookupData", int'(lookupData), qd[hitIdx]);
    // next state of the model
    oldRet = retCnt;
    newLen = cnt;
    if (fr) begin
      rel = (fi - headSlot + DEPTH) % DEPTH;
      if (rel < cnt) begin
        newLen = (rel + 1 < oldRet) ? oldRet : rel + 1;
        while (qa.size() > newLen) begin
          void'(qa.pop_back());
          void'(qd.pop_back());
        end
      end
    end
    if (rr && retCnt < newLen) retCnt++;
    doPop = mr && (oldRet > 0);
    if (doPop) begin
      void'(qa.pop_front());
      void'(qd.pop_front());
      retCnt--;
      headSlot = (headSlot + 1) % DEPTH;
    end
    if (pv && expReady) begin
      qa.push_back(pa);
      qd.push_back(pd);
    end
  endtask

  task automatic idle(input int la, input bit mr);
    step(0, 0, 0, 0, 0, 0, mr, la);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; pushValid = 0; pushAddr = 0; pushData = 0; retireReq = 0;
    flushReq = 0; flushIdx = 0; memWrReady = 0; lookupAddr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    curReq = "R1";                     // empty after reset
    idle('h10, 1);

    curReq = "R3";                     // three stores, two share an address
    step(1, 'h10, 1, 0, 0, 0, 0, 'h10);
    step(1, 'h20, 2, 0, 0, 0, 0, 'h10);
    step(1, 'h10, 3, 0, 0, 0, 0, 'h10);
    idle('h10, 0);
    idle('h20, 0);
    curReq = "R4";                     // absent address misses
    idle('h30, 0);

    curReq = "R2";                     // fill, then push into a full queue
    for (int i = 0; i < 6; i++) step(1, 'h50 + i, 'h500 + i, 0, 0, 0, 0, 'h10);
    step(1, 'h77, 'h777, 0, 0, 0, 0, 'h77);
    idle('h77, 0);

    curReq = "R5";                     // retire past the tail
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, 0, 0, 'h10);

    curReq = "R7";                     // memory stalls, entries stay visible
    for (int i = 0; i < 4; i++) idle('h10, 0);

    curReq = "R6";                     // drain in order
    for (int i = 0; i < 10; i++) idle('h10, 1);
    curReq = "R4";                     // drained entries no longer match
    idle('h10, 0);

    curReq = "R8";                     // cut inside the speculative region
    for (int i = 0; i < 6; i++) step(1, 'h40 + i, 'h100 + i, 0, 0, 0, 0, 'h40);
    step(0, 0, 0, 1, 0, 0, 0, 'h41);
    step(0, 0, 0, 1, 0, 0, 0, 'h41);
    step(0, 0, 0, 0, 1, slotOf(3), 0, 'h45);
    idle('h45, 0);
    idle('h43, 0);
    step(1, 'h99, 'h999, 0, 0, 0, 0, 'h99);
    idle('h99, 0);

    curReq = "R9";                     // aim at the oldest retired slot: clamp
    step(0, 0, 0, 0, 1, slotOf(0), 0, 'h42);
    idle('h42, 0);
    idle('h41, 0);
    step(0, 0, 0, 0, 1, slotOf(6), 0, 'h41);   // empty slot: ignored
    idle('h41, 0);

    curReq = "R10";                    // push, retire and commit together
    step(1, 'h60, 'h600, 1, 0, 0, 1, 'h60);
    step(1, 'h61, 'h601, 1, 0, 0, 1, 'h60);
    step(1, 'h62, 'h602, 0, 1, slotOf(0), 1, 'h62);  // flush drops the push
    idle('h62, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 1, 'h60);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 7, 'h100 + ($urandom % 4), $urandom % 'h10000,
           ($urandom % 2) == 1, ($urandom % 20) == 0, $urandom % DEPTH,
           ($urandom % 2) == 1, 'h100 + ($urandom % 5));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule